// File: doc/BRIEF.md
# Mode-Selectable Burst Address Sequencer

This block generates the low-order address of a four-beat burst for a synchronous burst memory interface. A controller pulses `load_i` when a new access starts. The full address on `addr_i` is captured, and it appears on `addr_o` in that same cycle through a bypass path. After that, each clock edge with `adv_i` high moves the low field to the next burst position. With no advance, the address holds. The upper address bits are passed through from the captured address without change. `last_o` marks the final beat of the burst.

The order of the sequence is chosen by the static input `mode_i`:

- **Linear order** (`mode_i` low): start plus beat count, modulo four.
- **Interleaved order** (`mode_i` high, or unknown in simulation): start XOR beat count.

A beat counter, kept separate from the emitted address, runs as a three-state machine:

- **States:** `PH_FIRST` (count zero), `PH_MID` (between first and last) and `PH_LAST` (count at its maximum).
- **LOAD:** from any state to `PH_FIRST`.
- **STEP:** on advance, `PH_FIRST` or `PH_MID` moves to `PH_MID`, or to `PH_LAST` when the new count is the maximum. `PH_LAST` moves to `PH_FIRST` (wrap).
- **HOLD:** stay in the current state.

Top module: `burst_seq`

## Requirements
- R1: After synchronous active-high reset, and before any load, `addr_o` is all zeros and `last_o` is 0.
- R2: With `mode_i`=0, the low two bits run s, s+1, s+2, s+3 modulo 4 from captured start s, one step per edge with `adv_i`=1 (start 01 gives 01,10,11,00).
- R3: With `mode_i`=1, the low two bits run s^00, s^01, s^10, s^11 (start 10 gives 10,11,00,01).
- R4: On an edge with `load_i`=0 and `adv_i`=0, `addr_o` and `last_o` keep their values.
- R5: In a cycle with `load_i`=1, `addr_o` equals `addr_i` and `last_o` is 0.
- R6: When `load_i` and `adv_i` are both 1 at an edge, the load wins: the next cycle shows the captured start address.
- R7: An advance from the fourth beat returns the low bits to the start value, and the sequence repeats.
- R8: `last_o` is 1 exactly when the beat count is 3 (the fourth position) and no load is present.
- R9: Bits above bit 1 of `addr_o` equal those of the last captured address whenever `load_i` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Static order select: 0 selects linear, 1 selects interleaved |
| load_i | input | 1 | Start a burst and capture `addr_i` |
| adv_i | input | 1 | Step to the next burst position |
| addr_i | input | ADDR_W | Start address of the access |
| addr_o | output | ADDR_W | Current burst address |
| last_o | output | 1 | High on the fourth beat |

## Verification
The bench builds the block with ADDR_W=8 and BURST_W=2. With these values, all four start positions in both orders can be swept in a few hundred cycles. Eight-bit addresses also make corruption of the upper bits visible through patterns like A5 and 5A. A two-bit counter wraps every four advances, so runs of five or more advances reach the wrap edge and the repeat of the sequence many times. Hold gaps and load-with-advance collisions are mixed into these runs.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Position of the beat counter inside a burst.
    typedef enum logic [1:0] {
        PH_FIRST = 2'd0,
        PH_MID   = 2'd1,
        PH_LAST  = 2'd2
    } phase_e;

    // Address order applied to the beat count.
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

endpackage

// File: rtl/burst_seq_beat_fsm.sv
module burst_seq_beat_fsm
    import burst_seq_pkg::*;
#(
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic               adv_i,
    output logic [BURST_W-1:0] beat_o,
    output logic               at_last_o
);
    localparam logic [BURST_W-1:0] BEAT_MAX = '1;

    phase_e             phase_q, phase_d;
    logic [BURST_W-1:0] beat_q, beat_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FIRST;
            beat_q  <= '0;
        end else begin
            phase_q <= phase_d;
            beat_q  <= beat_d;
        end
    end

    // Transitions: LOAD beats STEP, STEP beats HOLD.
    always_comb begin
        phase_d = phase_q;
        beat_d  = beat_q;
        if (load_i) begin
            phase_d = PH_FIRST;
            beat_d  = '0;
        end else if (adv_i) begin
            beat_d = beat_q + 1'b1;
            unique case (phase_q)
                PH_FIRST: phase_d = (beat_d == BEAT_MAX) ? PH_LAST : PH_MID;
                PH_MID:   phase_d = (beat_d == BEAT_MAX) ? PH_LAST : PH_MID;
                PH_LAST:  phase_d = PH_FIRST;
                default:  phase_d = PH_FIRST;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        beat_o    = beat_q;
        at_last_o = (phase_q == PH_LAST);
    end

endmodule

// File: rtl/burst_seq_capture.sv
module burst_seq_capture #(
    parameter int ADDR_W  = 32,
    parameter int BURST_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load_i,
    input  logic [ADDR_W-1:0]         addr_i,
    output logic [BURST_W-1:0]        start_o,
    output logic [ADDR_W-BURST_W-1:0] upper_o
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= addr_i;
        end
    end

    always_comb begin
        start_o = addr_q[BURST_W-1:0];
        upper_o = addr_q[ADDR_W-1:BURST_W];
    end

endmodule

// File: rtl/burst_seq_order_map.sv
module burst_seq_order_map
    import burst_seq_pkg::*;
#(
    parameter int BURST_W = 2
) (
    input  order_e             order_i,
    input  logic [BURST_W-1:0] start_i,
    input  logic [BURST_W-1:0] beat_i,
    output logic [BURST_W-1:0] low_o
);
    logic [BURST_W-1:0] lin_w;
    logic [BURST_W-1:0] xor_w;

    assign lin_w = start_i + beat_i;

    // Bitwise toggle of the start value by the beat count.
    for (genvar b = 0; b < BURST_W; b++) begin : g_xor
        assign xor_w[b] = start_i[b] ^ beat_i[b];
    end

    always_comb begin
        unique case (order_i)
            ORD_LINEAR: low_o = lin_w;
            ORD_XOR:    low_o = xor_w;
            default:    low_o = xor_w;
        endcase
    end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    localparam int UP_W = ADDR_W - BURST_W;

    order_e             order_w;
    logic [BURST_W-1:0] beat_w;
    logic               at_last_w;
    logic [BURST_W-1:0] start_w;
    logic [UP_W-1:0]    upper_w;
    logic [BURST_W-1:0] low_w;

    // An undriven or unknown mode falls to the interleaved order.
    assign order_w = (mode_i !== 1'b0) ? ORD_XOR : ORD_LINEAR;

    burst_seq_beat_fsm #(.BURST_W(BURST_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .adv_i     (adv_i),
        .beat_o    (beat_w),
        .at_last_o (at_last_w)
    );

    burst_seq_capture #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .addr_i  (addr_i),
        .start_o (start_w),
        .upper_o (upper_w)
    );

    burst_seq_order_map #(.BURST_W(BURST_W)) u_map (
        .order_i (order_w),
        .start_i (start_w),
        .beat_i  (beat_w),
        .low_o   (low_w)
    );

    // The first address of a burst reaches the core in its load cycle.
    always_comb begin
        if (load_i) begin
            addr_o = addr_i;
            last_o = 1'b0;
        end else begin
            addr_o = {upper_w, low_w};
            last_o = at_last_w;
        end
    end

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int ADDR_W  = 32,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_i,
    input logic              load_i,
    input logic              adv_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              last_o
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_load_bypass_R5: assert property (@(posedge clk) disable iff (rst)
        load_i |-> (addr_o == addr_i && !last_o));

    assert_load_first_R6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(load_i) && !load_i) |-> (addr_o == $past(addr_i) && !last_o));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!load_i && !adv_i) && !load_i && $stable(mode_i))
            |-> ($stable(addr_o) && $stable(last_o)));

    assert_linear_step_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(adv_i && !load_i && !mode_i) && !load_i && !mode_i)
            |-> ((addr_o[BURST_W-1:0] - $past(addr_o[BURST_W-1:0])) == BURST_W'(1)));

    assert_upper_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(load_i) && !load_i)
            |-> (addr_o[ADDR_W-1:BURST_W] == $past(addr_o[ADDR_W-1:BURST_W])));

    assert_last_wraps_R8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(last_o && adv_i && !load_i) && !load_i) |-> !last_o);

endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_i),
    .load_i (load_i),
    .adv_i  (adv_i),
    .addr_i (addr_i),
    .addr_o (addr_o),
    .last_o (last_o)
);

// File: tb/burst_seq_tb_top.sv
module burst_seq_tb_top;
    localparam int  AW     = 8;
    localparam int  BW     = 2;
    localparam time PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_i = 1'b0;
    logic          load_i = 1'b0;
    logic          adv_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;
    logic          last_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [AW-1:0] addr;
        logic          last;
        string         tag;
    } item_t;
    item_t sb_q[$];

    // Reference state.
    logic [AW-1:0] m_start = '0;
    logic [BW-1:0] m_beat  = '0;

    always #(PERIOD/2) clk = ~clk;

    burst_seq #(.ADDR_W(AW), .BURST_W(BW)) dut_i (
        .clk(clk), .rst(rst), .mode_i(mode_i), .load_i(load_i),
        .adv_i(adv_i), .addr_i(addr_i), .addr_o(addr_o), .last_o(last_o)
    );

    // Drive one cycle and push what the output must show in it.
    task automatic step(input bit ld, input bit adv, input logic [AW-1:0] a, input string tag);
        item_t it;
        logic [BW-1:0] lo;
        @(negedge clk);
        load_i = ld;
        adv_i  = adv;
        addr_i = a;
        if (ld) begin
            it.addr = a;
            it.last = 1'b0;
        end else begin
            lo = mode_i ? (m_start[BW-1:0] ^ m_beat) : (m_start[BW-1:0] + m_beat);
            it.addr = {m_start[AW-1:BW], lo};
            it.last = (m_beat == 2'd3);
        end
        it.tag = tag;
        sb_q.push_back(it);
        if (ld) begin
            m_start = a;
            m_beat  = '0;
        end else if (adv) begin
            m_beat = m_beat + 1'b1;
        end
    endtask

    // Monitor: compare a quarter period after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #(PERIOD/4);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (addr_o[BW-1:0] !== it.addr[BW-1:0]) begin
                    errors++;
                    $display("FAIL %s low addr: actual=%b expected=%b", it.tag, addr_o[BW-1:0], it.addr[BW-1:0]);
                end
                checks++;
                if (addr_o[AW-1:BW] !== it.addr[AW-1:BW]) begin
                    errors++;
                    $display("FAIL R9 upper addr: actual=%h expected=%h", addr_o[AW-1:BW], it.addr[AW-1:BW]);
                end
                checks++;
                if (last_o !== it.last) begin
                    errors++;
                    $display("FAIL R8 last: actual=%b expected=%b (%s)", last_o, it.last, it.tag);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(0, 0, 8'h00, "R1");
        step(0, 0, 8'h00, "R1");

        // Linear from 01: 01,10,11,00 then wrap.
        mode_i = 1'b0;
        step(1, 0, 8'hA5, "R5");
        for (int i = 0; i < 4; i++) step(0, 1, 8'h00, "R2");
        step(0, 1, 8'h00, "R7");
        step(0, 0, 8'h33, "R4");
        step(0, 0, 8'h33, "R4");

        // Load together with advance: load wins.
        step(1, 1, 8'h5A, "R6");
        step(0, 1, 8'h00, "R6");
        step(0, 1, 8'h00, "R2");

        // Interleaved from 10: 10,11,00,01 then wrap.
        mode_i = 1'b1;
        step(1, 0, 8'hC6, "R5");
        for (int i = 0; i < 4; i++) step(0, 1, 8'h00, "R3");
        step(0, 0, 8'hFF, "R4");
        step(0, 1, 8'h00, "R7");

        // All starts in both orders, with gaps and repeated wraps.
        for (int m = 0; m < 2; m++) begin
            mode_i = m[0];
            for (int s = 0; s < 4; s++) begin
                step(1, 0, 8'((s * 8'h41) ^ 8'h9C) & 8'hFC | 8'(s), "R5");
                for (int k = 0; k < 9; k++) begin
                    step(0, 1, 8'h00, m[0] ? "R3" : "R2");
                    if (k == 2) step(0, 0, 8'h00, "R4");
                end
                step(1, 1, 8'(s), "R6");
            end
        end
        step(0, 0, 8'h00, "R4");

        @(negedge clk);
        #(PERIOD/2);
        finish_run();
    end

endmodule